// File: doc/BRIEF.md
# BCD Calendar Clock Registers

This block holds a running calendar as eight packed-BCD byte registers: seconds, minutes, hours, day of month, month, two-digit year, weekday and century. A single-cycle `tick` pulse, normally raised once per second by a divider elsewhere on the chip, moves the calendar forward by one second. Carries pass through every field: minutes, hours, day of month with the correct month length and leap years, month, year and century.

The hour register can be in one of two encodings, chosen by its top bit. With the top bit set the hour counts 00 to 23 in BCD. With it clear the hour counts 1 to 12 in BCD, and a separate bit marks the afternoon. A host loads and inspects the registers through a byte port made of address, write data, write strobe and read data. An external enable input gates every write. A write takes priority over a tick that arrives in the same cycle, and that tick is dropped.

Top module: `bcd_cal_regs`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x80, date 0x01, month 0x01, year 0x00, weekday 0x00 and century 0x20. The registers sit at addresses BASE_ADDR+0 to +7 in the order seconds, minutes, hours, date, month, year, weekday, century (BASE_ADDR defaults to 0x30). Any address outside that window reads 0x00.
- R2: A write is accepted when `wr_stb` and `wr_en` are both high and the address is in the window. It stores the byte masked per field: seconds and minutes by 0x7F, date by 0x3F, month by 0x1F, weekday by 0x07, and hours, year and century all 8 bits. The stored value is readable in the cycle after the write edge.
- R3: A write strobe while `wr_en` is low changes nothing. A write strobe to an address outside the window changes nothing.
- R4: On a tick, seconds advance in BCD. At 0x59 they wrap to 0x00 and carry into minutes. Minutes wrap the same way at 0x59 and carry into the hour.
- R5: With hour bit 7 set (24-hour), the hour in bits 5:0 counts from 0x00 to 0x23. From 0x23 it wraps to 0x00 and carries into the date.
- R6: With hour bit 7 clear (12-hour), bits 4:0 hold 0x01 to 0x12 and bit 5 marks PM. 11 advances to 12 and flips bit 5. 12 advances to 01 and keeps bit 5. Only 11 PM advancing to 12 AM carries into the date.
- R7: On a date carry the date wraps to 0x01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the two-digit year is divisible by 4, and 28 otherwise. All other months have 31 days.
- R8: Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00, and a century of 0x19 then becomes 0x20.
- R9: The weekday advances by one on each date carry and wraps from 6 to 0.
- R10: A tick in the same cycle as an accepted write is dropped: only the written register changes. A tick in the same cycle as a rejected write is applied.
- R11: With no tick and no accepted write, all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that advances the calendar by one second |
| wr_en | input | 1 | External write gate; writes are ignored while low |
| wr_stb | input | 1 | Write strobe |
| addr | input | ADDR_W (8) | Register byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational in the default variant) |

## Verification
The assertions check on every cycle that:
- registers hold when nothing happens;
- a write lands masked;
- a coinciding write suppresses the tick;
- seconds and weekday wrap;
- the century only ever moves from 19;
- out-of-window reads return zero.

Full carry chains can only be shown by the bench's directed scenarios. These cover the 12-hour AM/PM sequence, month lengths, the leap-year February, and the year-and-century rollover, each compared against values worked out from the requirements.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

   localparam int NREG    = 8;
   localparam int IDX_SEC = 0;
   localparam int IDX_MIN = 1;
   localparam int IDX_HR  = 2;
   localparam int IDX_DAT = 3;
   localparam int IDX_MON = 4;
   localparam int IDX_YR  = 5;
   localparam int IDX_WD  = 6;
   localparam int IDX_CEN = 7;

   typedef logic [7:0] bcd_byte_t;

   // Two-digit BCD increment; callers handle the wrap values themselves.
   function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Bits each register keeps on a host write.
   function automatic bcd_byte_t field_mask(input int idx);
      case (idx)
         IDX_SEC, IDX_MIN: return 8'h7F;
         IDX_DAT:          return 8'h3F;
         IDX_MON:          return 8'h1F;
         IDX_WD:           return 8'h07;
         default:          return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/cal_clock_step.sv
module cal_clock_step
   import bcd_cal_pkg::*;
(
   input  bcd_byte_t sec,
   input  bcd_byte_t min,
   input  bcd_byte_t hr,
   output bcd_byte_t sec_n,
   output bcd_byte_t min_n,
   output bcd_byte_t hr_n,
   output logic      day_carry
);

   logic      sec_wrap, min_wrap, hour_adv;
   logic      wrap24, pm, pm_n, carry12;
   logic [4:0] h12, h12_n;
   bcd_byte_t h24_inc, h12_inc, sec_inc, min_inc;

   always_comb begin
      sec_inc  = bcd_inc(sec);
      min_inc  = bcd_inc(min);
      sec_wrap = (sec >= 8'h59);
      min_wrap = (min >= 8'h59);
      hour_adv = sec_wrap && min_wrap;

      sec_n = sec_wrap ? 8'h00 : (sec_inc & 8'h7F);
      min_n = !sec_wrap ? min : (min_wrap ? 8'h00 : (min_inc & 8'h7F));

      // 24-hour encoding
      wrap24  = ({2'b00, hr[5:0]} >= 8'h23);
      h24_inc = bcd_inc({2'b00, hr[5:0]});

      // 12-hour encoding with PM flag
      h12     = hr[4:0];
      pm      = hr[5];
      h12_inc = bcd_inc({3'b000, h12});
      carry12 = 1'b0;
      if (h12 >= 5'h12) begin
         h12_n = 5'h01;
         pm_n  = pm;
      end else if (h12 == 5'h11) begin
         h12_n   = 5'h12;
         pm_n    = ~pm;
         carry12 = pm;
      end else begin
         h12_n = h12_inc[4:0];
         pm_n  = pm;
      end

      if (!hour_adv)
         hr_n = hr;
      else if (hr[7])
         hr_n = {hr[7:6], wrap24 ? 6'h00 : h24_inc[5:0]};
      else
         hr_n = {hr[7:6], pm_n, h12_n};

      day_carry = hour_adv && (hr[7] ? wrap24 : carry12);
   end

endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
   import bcd_cal_pkg::*;
(
   input  bcd_byte_t mon,
   input  bcd_byte_t yr,
   output bcd_byte_t last_day
);

   logic [7:0] yr_bin;
   logic       leap;

   always_comb begin
      yr_bin = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
      leap   = (yr_bin[1:0] == 2'b00);
      case (mon)
         8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
         8'h02:                      last_day = leap ? 8'h29 : 8'h28;
         default:                    last_day = 8'h31;
      endcase
   end

endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
   import bcd_cal_pkg::*;
#(
   parameter int WD_LAST = 6
) (
   input  bcd_byte_t dat,
   input  bcd_byte_t mon,
   input  bcd_byte_t yr,
   input  bcd_byte_t wd,
   input  bcd_byte_t cen,
   input  bcd_byte_t last_day,
   input  logic      day_carry,
   output bcd_byte_t dat_n,
   output bcd_byte_t mon_n,
   output bcd_byte_t yr_n,
   output bcd_byte_t wd_n,
   output bcd_byte_t cen_n
);

   localparam bcd_byte_t WD_MAX = bcd_byte_t'(WD_LAST);

   logic      dat_end, mon_end, yr_end, mon_adv, yr_adv;
   bcd_byte_t dat_inc, mon_inc, yr_inc;

   always_comb begin
      dat_inc = bcd_inc(dat);
      mon_inc = bcd_inc(mon);
      yr_inc  = bcd_inc(yr);
      dat_end = (dat >= last_day);
      mon_end = (mon >= 8'h12);
      yr_end  = (yr  >= 8'h99);
      mon_adv = day_carry && dat_end;
      yr_adv  = mon_adv && mon_end;

      dat_n = !day_carry ? dat : (dat_end ? 8'h01 : (dat_inc & 8'h3F));
      mon_n = !mon_adv   ? mon : (mon_end ? 8'h01 : (mon_inc & 8'h1F));
      yr_n  = !yr_adv    ? yr  : (yr_end  ? 8'h00 : yr_inc);
      cen_n = (yr_adv && yr_end && cen == 8'h19) ? 8'h20 : cen;
      wd_n  = !day_carry ? wd  : ((wd >= WD_MAX) ? 8'h00 : wd + 8'h01);
   end

endmodule

// File: rtl/bcd_cal_regs.sv
module bcd_cal_regs
   import bcd_cal_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          BASE_ADDR     = 'h30,
   parameter logic [7:0]  RESET_CENTURY = 8'h20,
   parameter bit          RESET_24H     = 1'b1,
   parameter bit          READ_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data
);

   localparam int IDX_W = $clog2(NREG);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   if (BASE_ADDR + NREG > (1 << ADDR_W)) begin : g_bad_base
      $error("register window does not fit in the address space");
   end
   if (RESET_CENTURY != 8'h19 && RESET_CENTURY != 8'h20) begin : g_bad_cen
      $error("reset century must be BCD 19 or 20");
   end

   logic [NREG-1:0][7:0] regs_q, regs_d, step;
   logic [ADDR_W-1:0]    off;
   logic [IDX_W-1:0]     idx;
   logic                 in_win, wr_acc, day_carry;
   bcd_byte_t            last_day;

   assign off    = addr - BASE;
   assign in_win = (off < ADDR_W'(NREG));
   assign idx    = off[IDX_W-1:0];
   assign wr_acc = wr_stb && wr_en && in_win;

   cal_clock_step u_clock (
      .sec       (regs_q[IDX_SEC]),
      .min       (regs_q[IDX_MIN]),
      .hr        (regs_q[IDX_HR]),
      .sec_n     (step[IDX_SEC]),
      .min_n     (step[IDX_MIN]),
      .hr_n      (step[IDX_HR]),
      .day_carry (day_carry)
   );

   cal_month_days u_mdays (
      .mon      (regs_q[IDX_MON]),
      .yr       (regs_q[IDX_YR]),
      .last_day (last_day)
   );

   cal_date_step #(.WD_LAST(6)) u_date (
      .dat       (regs_q[IDX_DAT]),
      .mon       (regs_q[IDX_MON]),
      .yr        (regs_q[IDX_YR]),
      .wd        (regs_q[IDX_WD]),
      .cen       (regs_q[IDX_CEN]),
      .last_day  (last_day),
      .day_carry (day_carry),
      .dat_n     (step[IDX_DAT]),
      .mon_n     (step[IDX_MON]),
      .yr_n      (step[IDX_YR]),
      .wd_n      (step[IDX_WD]),
      .cen_n     (step[IDX_CEN])
   );

   // Accepted write wins; a tick in the same cycle is discarded.
   for (genvar i = 0; i < NREG; i++) begin : g_next
      assign regs_d[i] = wr_acc ? ((idx == IDX_W'(i)) ? (wr_data & field_mask(i)) : regs_q[i])
                       : tick   ? step[i]
                       :          regs_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q          <= '0;
         regs_q[IDX_HR]  <= RESET_24H ? 8'h80 : 8'h12;
         regs_q[IDX_DAT] <= 8'h01;
         regs_q[IDX_MON] <= 8'h01;
         regs_q[IDX_CEN] <= RESET_CENTURY;
      end else begin
         regs_q <= regs_d;
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rd_data <= '0;
         else if (in_win) rd_data <= regs_q[idx];
         else             rd_data <= '0;
      end
   end else begin : g_rd_comb
      assign rd_data = in_win ? regs_q[idx] : 8'h00;

      // R1
      rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_win |-> rd_data == 8'h00);
   end

   // R2
   wr_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc && idx == IDX_W'(IDX_SEC) |=> regs_q[IDX_SEC] == ($past(wr_data) & 8'h7F));

   // R10
   drop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc && tick && idx != IDX_W'(IDX_SEC) |=> $stable(regs_q[IDX_SEC]));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !wr_acc |=> $stable(regs_q));

   // R4
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !wr_acc && regs_q[IDX_SEC] == 8'h59 |=> regs_q[IDX_SEC] == 8'h00);

   // R9
   wd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !wr_acc && day_carry && regs_q[IDX_WD] == 8'h06 |=> regs_q[IDX_WD] == 8'h00);

   // R8
   cen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_acc && regs_q[IDX_CEN] != 8'h19 |=> $stable(regs_q[IDX_CEN]));

endmodule

// File: tb/bcd_cal_regs_tb.sv
`timescale 1ns/1ps
module bcd_cal_regs_tb;

   localparam int BASE = 'h30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bcd_cal_regs u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_en),
      .wr_stb  (wr_stb),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
      end
   endtask

   // All drives happen at the falling edge.
   task automatic cyc(input logic t, input logic en, input logic stb, input logic [7:0] a, input logic [7:0] d);
      tick = t; wr_en = en; wr_stb = stb; addr = a; wr_data = d;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0; wr_stb = 1'b0;
   endtask

   task automatic wr(input int i, input logic [7:0] d);
      cyc(1'b0, 1'b1, 1'b1, 8'(BASE + i), d);
   endtask

   task automatic rd_at(input logic [7:0] a, output logic [7:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic expect_reg(input string req, input int i, input logic [7:0] exp);
      logic [7:0] v;
      rd_at(8'(BASE + i), v);
      chk(req, $sformatf("reg%0d", i), v, exp);
   endtask

   task automatic set_all(input logic [7:0] cen, yr, mo, dt, wd, hr, mn, sc);
      wr(7, cen); wr(5, yr); wr(4, mo); wr(3, dt);
      wr(6, wd);  wr(2, hr); wr(1, mn); wr(0, sc);
   endtask

   task automatic do_tick();
      cyc(1'b1, 1'b0, 1'b0, addr, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00);
      expect_reg("R1", 2, 8'h80); expect_reg("R1", 3, 8'h01);
      expect_reg("R1", 4, 8'h01); expect_reg("R1", 5, 8'h00);
      expect_reg("R1", 6, 8'h00); expect_reg("R1", 7, 8'h20);
      rd_at(8'h2F, v); chk("R1", "below window", v, 8'h00);
      rd_at(8'h38, v); chk("R1", "above window", v, 8'h00);
   endtask

   task automatic t_write_mask();
      for (int i = 0; i < 8; i++) wr(i, 8'hFF);
      expect_reg("R2", 0, 8'h7F); expect_reg("R2", 1, 8'h7F);
      expect_reg("R2", 2, 8'hFF); expect_reg("R2", 3, 8'h3F);
      expect_reg("R2", 4, 8'h1F); expect_reg("R2", 5, 8'hFF);
      expect_reg("R2", 6, 8'h07); expect_reg("R2", 7, 8'hFF);
   endtask

   task automatic t_ignored();
      set_all(8'h20, 8'h24, 8'h03, 8'h15, 8'h02, 8'h90, 8'h20, 8'h30);
      cyc(1'b0, 1'b0, 1'b1, 8'(BASE), 8'h45);
      expect_reg("R3", 0, 8'h30);
      cyc(1'b0, 1'b1, 1'b1, 8'(BASE + 8), 8'h45);
      cyc(1'b0, 1'b1, 1'b1, 8'(BASE - 1), 8'h45);
      for (int i = 0; i < 8; i++) expect_reg("R3", i, (i==0)?8'h30:(i==1)?8'h20:(i==2)?8'h90:
         (i==3)?8'h15:(i==4)?8'h03:(i==5)?8'h24:(i==6)?8'h02:8'h20);
   endtask

   task automatic t_sec_min();
      set_all(8'h20, 8'h24, 8'h03, 8'h15, 8'h02, 8'h85, 8'h12, 8'h58);
      do_tick(); expect_reg("R4", 0, 8'h59); expect_reg("R4", 1, 8'h12);
      do_tick(); expect_reg("R4", 0, 8'h00); expect_reg("R4", 1, 8'h13);
      wr(1, 8'h59); wr(0, 8'h59);
      do_tick(); expect_reg("R4", 1, 8'h00); expect_reg("R5", 2, 8'h86);
   endtask

   task automatic t_24h();
      set_all(8'h20, 8'h24, 8'h03, 8'h10, 8'h03, 8'hA3, 8'h59, 8'h59);
      do_tick();
      expect_reg("R5", 2, 8'h80); expect_reg("R5", 3, 8'h11);
      expect_reg("R9", 6, 8'h04);
   endtask

   task automatic t_12h();
      set_all(8'h20, 8'h24, 8'h03, 8'h05, 8'h01, 8'h11, 8'h59, 8'h59);
      do_tick(); expect_reg("R6", 2, 8'h32); expect_reg("R6", 3, 8'h05);
      wr(1, 8'h59); wr(0, 8'h59);
      do_tick(); expect_reg("R6", 2, 8'h21);
      wr(2, 8'h31); wr(1, 8'h59); wr(0, 8'h59);
      do_tick(); expect_reg("R6", 2, 8'h12); expect_reg("R6", 3, 8'h06);
      wr(1, 8'h59); wr(0, 8'h59);
      do_tick(); expect_reg("R6", 2, 8'h01); expect_reg("R6", 3, 8'h06);
   endtask

   task automatic day_end(input logic [7:0] yr, mo, dt);
      set_all(8'h20, yr, mo, dt, 8'h00, 8'hA3, 8'h59, 8'h59);
      do_tick();
   endtask

   task automatic t_months();
      day_end(8'h23, 8'h04, 8'h30); expect_reg("R7", 3, 8'h01); expect_reg("R7", 4, 8'h05);
      day_end(8'h23, 8'h05, 8'h30); expect_reg("R7", 3, 8'h31); expect_reg("R7", 4, 8'h05);
      day_end(8'h23, 8'h02, 8'h28); expect_reg("R7", 3, 8'h01); expect_reg("R7", 4, 8'h03);
      day_end(8'h24, 8'h02, 8'h28); expect_reg("R7", 3, 8'h29);
      day_end(8'h12, 8'h02, 8'h28); expect_reg("R7", 3, 8'h29);
      day_end(8'h00, 8'h02, 8'h28); expect_reg("R7", 3, 8'h29);
      day_end(8'h24, 8'h02, 8'h29); expect_reg("R7", 3, 8'h01); expect_reg("R7", 4, 8'h03);
      day_end(8'h23, 8'h11, 8'h30); expect_reg("R7", 4, 8'h12);
   endtask

   task automatic t_year();
      set_all(8'h19, 8'h99, 8'h12, 8'h31, 8'h05, 8'hA3, 8'h59, 8'h59);
      do_tick();
      expect_reg("R8", 3, 8'h01); expect_reg("R8", 4, 8'h01);
      expect_reg("R8", 5, 8'h00); expect_reg("R8", 7, 8'h20);
      day_end(8'h45, 8'h12, 8'h31);
      expect_reg("R8", 5, 8'h46); expect_reg("R8", 7, 8'h20);
   endtask

   task automatic t_weekday();
      set_all(8'h20, 8'h24, 8'h03, 8'h10, 8'h06, 8'hA3, 8'h59, 8'h59);
      do_tick(); expect_reg("R9", 6, 8'h00);
      wr(2, 8'hA3); wr(1, 8'h59); wr(0, 8'h59);
      do_tick(); expect_reg("R9", 6, 8'h01);
   endtask

   task automatic t_drop();
      set_all(8'h20, 8'h24, 8'h03, 8'h10, 8'h02, 8'h85, 8'h20, 8'h10);
      cyc(1'b1, 1'b1, 1'b1, 8'(BASE + 1), 8'h33);
      expect_reg("R10", 0, 8'h10); expect_reg("R10", 1, 8'h33);
      cyc(1'b1, 1'b0, 1'b1, 8'(BASE + 1), 8'h44);
      expect_reg("R10", 0, 8'h11); expect_reg("R10", 1, 8'h33);
   endtask

   task automatic t_idle();
      set_all(8'h20, 8'h24, 8'h03, 8'h10, 8'h02, 8'h85, 8'h20, 8'h10);
      repeat (6) @(negedge clk);
      expect_reg("R11", 0, 8'h10); expect_reg("R11", 2, 8'h85);
      expect_reg("R11", 3, 8'h10);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_mask();
      t_ignored();
      t_sec_min();
      t_24h();
      t_12h();
      t_months();
      t_year();
      t_weekday();
      t_drop();
      t_idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule